// File: doc/BRIEF.md
# Reloadable Countdown Timer

This block is a down-counting timer with a four-word register window on a simple synchronous bus and a single interrupt line. A prescaler derived from the system clock produces count ticks. While the run bit is set, each tick lowers the counter by one. A tick that finds the counter at zero is an underflow. On underflow the counter reloads and an interrupt event is raised.

A control bit picks the reload value. It is either the programmed load value or the all-ones maximum of the counter width. A second control bit makes the interrupt status sticky. In that mode the status stays set until software clears it, and no new interrupt edge appears while it is set, although counting goes on. With the bit clear, the status lasts one cycle per underflow and the interrupt line pulses.

Software writes the load register while the timer is stopped, which also primes the counter. It then sets the run bit and either services sticky interrupts or takes pulses.

Top module: `rld_timer`

## Requirements
- R1: After reset, the load, count and control registers read zero and `irq_o` is low.
- R2: The byte offsets are 0x0 load, 0x4 count, 0x8 control and 0xC status. Load holds only the low CNT_W bits of a write. Count ignores writes. The control fields are hold at bit 0, prescale code at bits 3:2, reload-from-load at bit 6, run at bit 7 and status at bit 8. Bit 8 is read-only and ignores writes. All other read bits are zero.
- R3: A write to load while run is clear also sets the counter to the written value. A write to load while run is set leaves the counter untouched.
- R4: Each tick lowers a nonzero counter by one. A tick at zero is an underflow. With load value L and divide factor D, underflows repeat every (L+1)·D cycles. The first underflow comes (L+1)·D cycles after the write that sets run.
- R5: On underflow the counter reloads from the load register if bit 6 is set, and to 2^CNT_W−1 if bit 6 is clear.
- R6: Prescale code 0 divides by 1, code 1 by 16, and codes 2 and 3 by 256. The prescaler restarts when run goes from 0 to 1.
- R7: With hold clear, each underflow sets the status for exactly one cycle, and `irq_o` is a one-cycle pulse in the cycle after the underflow.
- R8: With hold set, the status and `irq_o` stay high after an underflow while counting continues. Writing zero to offset 0xC clears them. A nonzero write there has no effect.
- R9: A read of offset 0xC returns the load register value.
- R10: With run clear, the counter and the prescaler do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, valid with sel_i |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt: a pulse with hold clear, a level with hold set |

## Verification
The bench sweeps every prescale code over several small load values. It measures both the first period after start and the steady period against (L+1)·D. An off-by-one in the underflow point, or a prescaler that is not restarted on run, would show up there as a wrong cycle count. Reload-to-maximum is timed over a full wrap. A design that always reloaded from the load register would return after L+1 cycles instead of 2^CNT_W. In sticky mode the bench keeps the timer running well past several underflows and checks that the line stays high and that only a zero write drops it. A design that let later underflows re-pulse the line, or that cleared on any write, would fail those checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] OFF_LOAD = 4'h0;
  localparam logic [3:0] OFF_CNT  = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h8;
  localparam logic [3:0] OFF_STAT = 4'hC;

  localparam int BIT_HOLD   = 0;
  localparam int BIT_DIV_LO = 2;
  localparam int BIT_RELOAD = 6;
  localparam int BIT_RUN    = 7;
  localparam int BIT_STAT   = 8;

  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_16   = 2'd1,
    DIV_256  = 2'd2,
    DIV_256B = 2'd3
  } div_e;

  typedef struct packed {
    logic run;
    logic reload;
    div_e div;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_LO = 4,
  parameter int PRE_HI = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  div_e div_i,
  output logic tick_o
);
  logic [PRE_HI-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (run_i)     pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (div_i)
      DIV_1:   tick_o = run_i;
      DIV_16:  tick_o = run_i && (&pre_q[PRE_LO-1:0]);
      default: tick_o = run_i && (&pre_q);
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             reload_sel_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             prime_i,
  input  logic [CNT_W-1:0] prime_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire_o  = tick_i && at_zero;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (prime_i && !run_i) cnt_q <= prime_val_i;
    else if (tick_i)           cnt_q <= at_zero ? (reload_sel_i ? load_val_i : CNT_MAX)
                                                : cnt_q - 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 23,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              fire_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              load_wr_o,
  output logic              run_rise_o,
  output logic              stat_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic             stat_q;
  logic             wr, ctrl_wr, stat_clr;
  logic             unused_wdata;

  assign wr         = sel_i && we_i;
  assign load_wr_o  = wr && (addr_i == ADDR_W'(OFF_LOAD));
  assign ctrl_wr    = wr && (addr_i == ADDR_W'(OFF_CTRL));
  assign stat_clr   = wr && (addr_i == ADDR_W'(OFF_STAT)) && (wdata_i == '0);
  assign run_rise_o = ctrl_wr && wdata_i[BIT_RUN] && !ctrl_q.run;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (load_wr_o) load_q <= wdata_i[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl_q.hold   <= wdata_i[BIT_HOLD];
        ctrl_q.div    <= div_e'(wdata_i[BIT_DIV_LO+1:BIT_DIV_LO]);
        ctrl_q.reload <= wdata_i[BIT_RELOAD];
        ctrl_q.run    <= wdata_i[BIT_RUN];
      end
    end
  end

  // underflow beats a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           stat_q <= 1'b0;
    else if (fire_i)       stat_q <= 1'b1;
    else if (!ctrl_q.hold) stat_q <= 1'b0;
    else if (stat_clr)     stat_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFF_LOAD), ADDR_W'(OFF_STAT): rdata_o[CNT_W-1:0] = load_q;
      ADDR_W'(OFF_CNT):  rdata_o[CNT_W-1:0] = cnt_i;
      ADDR_W'(OFF_CTRL): begin
        rdata_o[BIT_HOLD]                 = ctrl_q.hold;
        rdata_o[BIT_DIV_LO+1:BIT_DIV_LO]  = ctrl_q.div;
        rdata_o[BIT_RELOAD]               = ctrl_q.reload;
        rdata_o[BIT_RUN]                  = ctrl_q.run;
        rdata_o[BIT_STAT]                 = stat_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 23,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int PRE_LO = 4,
  parameter int PRE_HI = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_q, cnt;
  logic             load_wr, run_rise, stat, tick, fire;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .fire_i(fire), .ctrl_o(ctrl), .load_o(load_q),
    .load_wr_o(load_wr), .run_rise_o(run_rise), .stat_o(stat)
  );

  tmr_prescaler #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) i_pre (
    .clk_i, .rst_ni, .run_i(ctrl.run), .restart_i(run_rise),
    .div_i(ctrl.div), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .run_i(ctrl.run),
    .reload_sel_i(ctrl.reload), .load_val_i(load_q),
    .prime_i(load_wr), .prime_val_i(wdata_i[CNT_W-1:0]),
    .cnt_o(cnt), .fire_o(fire)
  );

  // pulse with hold clear (status lasts one cycle), level with hold set
  assign irq_o = stat;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 23,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              tick_i,
  input logic              fire_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  load_i,
  input logic              run_i,
  input logic              reload_i,
  input logic              hold_i,
  input logic              stat_i,
  input logic              load_wr_i
);
  logic stat_clr;
  assign stat_clr = sel_i && we_i && (addr_i == ADDR_W'(OFF_STAT)) && (wdata_i == '0);

  // R10
  no_tick_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_i);
  // R10
  stopped_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_wr_i) |=> $stable(cnt_i));
  // R4
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - 1'b1);
  // R5
  reload_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == '0 && reload_i) |=> cnt_i == $past(load_i));
  // R5
  reload_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == '0 && !reload_i) |=> &cnt_i);
  // R7
  fire_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> irq_o);
  // R7
  auto_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && stat_i && !fire_i) |=> !stat_i);
  // R8
  hold_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && stat_i && !stat_clr) |=> stat_i);
endmodule

bind rld_timer tmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .tick_i(tick), .fire_i(fire), .cnt_i(cnt),
  .load_i(load_q), .run_i(ctrl.run), .reload_i(ctrl.reload), .hold_i(ctrl.hold),
  .stat_i(stat), .load_wr_i(load_wr)
);

// File: tb/test_rld_timer.sv
module test_rld_timer;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              irq_o;

  int checks = 0, errors = 0;

  rld_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rld_timer (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  // negedges until irq_o is seen, -1 on timeout
  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq_o && n < lim) begin @(negedge clk_i); n++; end
    if (!irq_o) n = -1;
  endtask

  // from a pulse: check it is one cycle wide, then cycles to the next
  task automatic gap(input string req, input int lim, output int n);
    @(negedge clk_i);
    check({req, " pulse width (R7)"}, irq_o, 0);
    n = 1;
    while (!irq_o && n < lim) begin @(negedge clk_i); n++; end
    if (!irq_o) n = -1;
  endtask

  function automatic int divf(input int code);
    return (code == 0) ? 1 : (code == 1) ? 16 : 256;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(4'h0, v); check("R1 load", v, 0);
    rd(4'h4, v); check("R1 count", v, 0);
    rd(4'h8, v); check("R1 ctrl", v, 0);
    check("R1 irq", irq_o, 0);

    // R2 field map, masking, read-only bits
    wr(4'h8, 32'h14D);
    rd(4'h8, v); check("R2 ctrl readback, bit8 ignored", v, 32'h4D);
    wr(4'h0, 32'h1234);
    rd(4'h0, v); check("R2 load masked", v, 32'h34);
    // R9
    rd(4'hC, v); check("R9 status reads load", v, 32'h34);
    wr(4'h4, 32'h77);
    rd(4'h4, v); check("R2 count ignores write", v, 32'h34);
    rd(4'h1, v); check("R2 unmapped reads zero", v, 0);

    // R3 load write while stopped primes the counter
    wr(4'h8, 0);
    wr(4'h0, 9);
    rd(4'h4, v); check("R3 count primed", v, 9);

    // R4 R6 period sweep over every prescale code
    for (int dc = 0; dc < 4; dc++) begin
      for (int l = 1; l <= 5; l++) begin
        int exp;
        exp = (l + 1) * divf(dc);
        wr(4'h8, 0);
        wr(4'h0, l);
        wr(4'h8, 32'hC0 | (dc << 2));
        wait_irq(3000, n);
        check($sformatf("R4 R6 first period div%0d load%0d", dc, l), n, exp);
        gap("R4", 3000, n);
        check($sformatf("R4 R6 steady period div%0d load%0d", dc, l), n, exp);
      end
    end

    // R5 reload to maximum when bit 6 clear
    wr(4'h8, 0);
    wr(4'h0, 3);
    wr(4'h8, 32'h80);
    wait_irq(1000, n); check("R5 first period", n, 4);
    gap("R5", 1000, n); check("R5 wrap to max period", n, CMAX + 1);

    // R10 stopped counter frozen, R3 reload while stopped
    wr(4'h8, 32'h40);
    rd(4'h4, a);
    repeat (20) @(negedge clk_i);
    rd(4'h4, v); check("R10 count frozen", v, a);
    check("R10 no irq while stopped", irq_o, 0);

    // R3 load write while running leaves count
    wr(4'h0, 9);
    wr(4'h8, 32'hC8);
    rd(4'h4, a); check("R3 count before running write", a, 9);
    wr(4'h0, 30);
    rd(4'h4, v); check("R3 count untouched while running", v, 9);
    rd(4'h0, v); check("R3 load updated while running", v, 30);

    // R8 sticky status
    wr(4'h8, 0);
    wr(4'h0, 40);
    wr(4'h8, 32'hC1);
    wait_irq(100, n); check("R8 first underflow", n, 41);
    repeat (100) @(negedge clk_i);
    check("R8 irq held", irq_o, 1);
    rd(4'h8, v); check("R8 status bit held", v[8], 1);
    rd(4'h4, a);
    @(negedge clk_i);
    rd(4'h4, v); check("R8 counting continues", v, (a == 0) ? 40 : a - 1);
    wr(4'hC, 5);
    check("R8 nonzero write ignored", irq_o, 1);
    wr(4'h8, 32'h41);
    check("R8 held after stop", irq_o, 1);
    wr(4'hC, 0);
    check("R8 zero write clears", irq_o, 0);
    rd(4'h8, v); check("R8 status bit cleared", v[8], 0);
    wr(4'h8, 32'hC1);
    wait_irq(60, n); check("R8 rearmed after clear", n > 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule